// File: doc/BRIEF.md
# Mode-Switched I/O Port with Address Takeover

This block controls one 8-pin general-purpose port of a microcontroller. Software reaches it through a small byte-wide register bus. Five registers sit on that bus:

- a direction register, which can be written but not read back;
- an output data register;
- a read-only pin-level register;
- a pull-up enable register;
- an open-drain enable register.

From those registers, the operating-mode input and an external address bus, the block computes three signals for every pad: an output value, an output enable and a pull-up enable. All of them leave the block from flip-flops.

In the expanded operating modes the low pins of the port become address outputs. Pins 0 to 4 are always address outputs in those modes. Pins 5 to 7 become address outputs only when their direction bit is set. In the general-purpose modes, the direction bits alone decide whether a pin is an input or an output.

Two kinds of reset are handled. A power-on reset clears the direction state, while a manual reset keeps it. There are also two low-power states. Hardware standby parks every pad. In software standby, an output-hold input decides whether the pins that carry address keep their last value or float.

Top module: `mpio_port`

## Requirements
- R1: Registers decode at these 16-bit addresses: direction 0xFEB9, data 0xFF69, pin level 0xFF59, pull-up 0xFF70, open-drain 0xFF77. Data, pull-up and open-drain read back what was written. A read of any other address returns 0x00, and a write to any other address, or to the pin-level register, changes nothing.
- R2: A read of the direction register returns 0xFF, whatever the register holds.
- R3: Bit i of the pin-level read is the data bit when pin i is a general-purpose output, and the live pad input level otherwise.
- R4: While power-on reset or hardware standby is high, all four writable registers clear to 0x00 and every pad output, output enable and pull-up is 0. The cleared direction register is still in effect after release.
- R5: A manual reset clears data, pull-up, open-drain and the read data, and forces the pads to 0 for that cycle. The direction register keeps its value.
- R6: In modes 1, 2, 3 and 7, a pin whose direction bit is 1 drives its data bit with the output enable high. A pin whose direction bit is 0 is an input, with output and enable both 0.
- R7: In modes 4 and 5, pins 0 to 4 drive the matching address-bus bit with the output enable high, for any direction value.
- R8: In modes 4 and 5, pins 5 to 7 drive their address bit when their direction bit is 1, and are inputs when it is 0.
- R9: In software standby, an address-output pin keeps its previous output with the enable high when the hold input is 1. When the hold input is 0, its output and enable are 0.
- R10: A general-purpose output whose open-drain bit is 1 drives 0 with the enable high for data 0. For data 1 it releases, with output and enable both 0.
- R11: The pull-up enable of a pin is its pull-up bit when the pin is an input, and 0 otherwise.
- R12: In modes 0 and 6, every pin is an input.
- R13: Pad outputs change on the clock edge after the register or input change that causes them. A read returns its value on the edge after the read strobe, or 0x00 if there was no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| hold_en | input | 1 | In software standby, keep address outputs driven |
| mode | input | 3 | Operating mode |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| addr_bus | input | 8 | Address bits to put on the port |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
The assertions check these properties on every cycle:
- the reset and hardware-standby clearing;
- that the direction register survives a manual reset;
- that pins 0 to 4 follow the address bus in the expanded modes;
- the software-standby hold;
- that a pull-up is never enabled on a driving pad;
- the 0xFF direction read.

Only the bench scenarios can show how the direction bits, the modes, open-drain and pull-up combine on each pin. The same holds for the pin-level readback under mixed roles, and for the fact that writes to unmapped or read-only addresses leave state alone.

// File: rtl/mpio_pkg.sv
package mpio_pkg;

  localparam int MODE_W = 3;

  typedef logic [MODE_W-1:0] mode_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_DAT,
    SEL_PIN,
    SEL_PU,
    SEL_OD
  } reg_sel_e;

  // Expanded modes: low pins carry the address
  function automatic logic addr_mode(input mode_t m);
    return (m == 3'd4) || (m == 3'd5);
  endfunction

  // Single-chip style modes: direction bits alone decide
  function automatic logic gp_mode(input mode_t m);
    return (m == 3'd1) || (m == 3'd2) || (m == 3'd3) || (m == 3'd7);
  endfunction

endpackage

// File: rtl/mpio_regs.sv
module mpio_regs
  import mpio_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] A_DIR = 16'hFEB9,
  parameter logic [AW-1:0] A_DAT = 16'hFF69,
  parameter logic [AW-1:0] A_PIN = 16'hFF59,
  parameter logic [AW-1:0] A_PU  = 16'hFF70,
  parameter logic [AW-1:0] A_OD  = 16'hFF77
) (
  input  logic          clk,
  input  logic          por_rst,
  input  logic          man_rst,
  input  logic          hw_stby,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output reg_sel_e      sel,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  dat_q,
  output logic [W-1:0]  pu_q,
  output logic [W-1:0]  od_q
);

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == A_DIR) sel = SEL_DIR;
    else if (bus_addr == A_DAT) sel = SEL_DAT;
    else if (bus_addr == A_PIN) sel = SEL_PIN;
    else if (bus_addr == A_PU)  sel = SEL_PU;
    else if (bus_addr == A_OD)  sel = SEL_OD;
  end

  // Direction: cleared only by power-on reset or hardware standby
  always_ff @(posedge clk) begin
    if (por_rst || hw_stby) begin
      dir_q <= '0;
    end else if (!man_rst && bus_wr && sel == SEL_DIR) begin
      dir_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst || hw_stby || man_rst) begin
      dat_q <= '0;
      pu_q  <= '0;
      od_q  <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DAT: dat_q <= bus_wdata;
        SEL_PU:  pu_q  <= bus_wdata;
        SEL_OD:  od_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  // R4: power-on reset or hardware standby leaves every register cleared
  a_r4_regs_cleared: assert property (@(posedge clk) disable iff (man_rst)
    (por_rst || hw_stby) |=> (dir_q == '0 && dat_q == '0 && pu_q == '0 && od_q == '0));

  // R5: manual reset keeps the direction register
  a_r5_dir_kept: assert property (@(posedge clk) disable iff (por_rst || hw_stby)
    man_rst |=> (dir_q == $past(dir_q)));

endmodule

// File: rtl/mpio_pin_fn.sv
module mpio_pin_fn
  import mpio_pkg::*;
#(
  parameter int W = 8,
  parameter int ADDR_FIXED = 5
) (
  input  mode_t        mode,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] is_addr,
  output logic [W-1:0] is_gpo
);

  logic am;
  logic gm;

  assign am = addr_mode(mode);
  assign gm = gp_mode(mode);

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i < ADDR_FIXED) begin : g_fixed
      assign is_addr[i] = am;
    end else begin : g_sel
      assign is_addr[i] = am & dir_q[i];
    end
    assign is_gpo[i] = gm & dir_q[i];
  end

endmodule

// File: rtl/mpio_pad_drv.sv
module mpio_pad_drv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_rst,
  input  logic         man_rst,
  input  logic         hw_stby,
  input  logic         sw_stby,
  input  logic         hold_en,
  input  logic [W-1:0] is_addr,
  input  logic [W-1:0] is_gpo,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] od_q,
  input  logic [W-1:0] pu_q,
  input  logic [W-1:0] addr_bus,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu
);

  for (genvar i = 0; i < W; i++) begin : g_pad
    always_ff @(posedge clk) begin
      if (por_rst || man_rst || hw_stby) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
        pad_pu[i]  <= 1'b0;
      end else if (is_addr[i]) begin
        pad_pu[i] <= 1'b0;
        if (sw_stby) begin
          pad_oe[i]  <= hold_en;
          pad_out[i] <= hold_en ? pad_out[i] : 1'b0;
        end else begin
          pad_oe[i]  <= 1'b1;
          pad_out[i] <= addr_bus[i];
        end
      end else if (is_gpo[i]) begin
        pad_pu[i] <= 1'b0;
        if (od_q[i]) begin
          pad_out[i] <= 1'b0;
          pad_oe[i]  <= ~dat_q[i];
        end else begin
          pad_out[i] <= dat_q[i];
          pad_oe[i]  <= 1'b1;
        end
      end else begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
        pad_pu[i]  <= pu_q[i];
      end
    end
  end

  // R4: hardware standby parks every pad
  a_r4_hw_stby_parked: assert property (@(posedge clk) disable iff (por_rst)
    hw_stby |=> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

  // R11: a driven pad never has its pull-up on
  a_r11_pu_not_driven: assert property (@(posedge clk) disable iff (por_rst)
    (pad_pu & pad_oe) == '0);

  // R9: in software standby with hold, address pins keep their value
  a_r9_hold_value: assert property (@(posedge clk) disable iff (por_rst)
    (sw_stby && hold_en && !man_rst && !hw_stby)
      |=> ((pad_out & $past(is_addr)) == ($past(pad_out) & $past(is_addr))));

endmodule

// File: rtl/mpio_rd_mux.sv
module mpio_rd_mux
  import mpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_rst,
  input  logic         man_rst,
  input  logic         hw_stby,
  input  logic         bus_rd,
  input  reg_sel_e     sel,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] pu_q,
  input  logic [W-1:0] od_q,
  input  logic [W-1:0] is_gpo,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] bus_rdata
);

  logic [W-1:0] pin_val;
  logic [W-1:0] rd_next;

  assign pin_val = (is_gpo & dat_q) | (~is_gpo & pad_in);

  always_comb begin
    rd_next = '0;
    if (bus_rd) begin
      case (sel)
        SEL_DIR: rd_next = '1;
        SEL_DAT: rd_next = dat_q;
        SEL_PIN: rd_next = pin_val;
        SEL_PU:  rd_next = pu_q;
        SEL_OD:  rd_next = od_q;
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst || man_rst || hw_stby) bus_rdata <= '0;
    else                               bus_rdata <= rd_next;
  end

  // R2: direction reads return all ones
  a_r2_dir_read_ones: assert property (@(posedge clk) disable iff (por_rst)
    (bus_rd && sel == SEL_DIR && !man_rst && !hw_stby) |=> (bus_rdata == '1));

  // R13: no strobe, no data
  a_r13_idle_zero: assert property (@(posedge clk) disable iff (por_rst)
    !bus_rd |=> (bus_rdata == '0));

endmodule

// File: rtl/mpio_port.sv
module mpio_port
  import mpio_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 16,
  parameter int ADDR_FIXED = 5,
  parameter logic [AW-1:0] A_DIR = 16'hFEB9,
  parameter logic [AW-1:0] A_DAT = 16'hFF69,
  parameter logic [AW-1:0] A_PIN = 16'hFF59,
  parameter logic [AW-1:0] A_PU  = 16'hFF70,
  parameter logic [AW-1:0] A_OD  = 16'hFF77
) (
  input  logic          clk,
  input  logic          por_rst,
  input  logic          man_rst,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic          hold_en,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  addr_bus,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu
);

  localparam int AF = (ADDR_FIXED < W) ? ADDR_FIXED : W;

  reg_sel_e     sel;
  logic [W-1:0] dir_q;
  logic [W-1:0] dat_q;
  logic [W-1:0] pu_q;
  logic [W-1:0] od_q;
  logic [W-1:0] is_addr;
  logic [W-1:0] is_gpo;

  mpio_regs #(
    .W(W), .AW(AW), .A_DIR(A_DIR), .A_DAT(A_DAT),
    .A_PIN(A_PIN), .A_PU(A_PU), .A_OD(A_OD)
  ) u_regs (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .hw_stby(hw_stby),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .sel(sel), .dir_q(dir_q), .dat_q(dat_q), .pu_q(pu_q), .od_q(od_q)
  );

  mpio_pin_fn #(.W(W), .ADDR_FIXED(AF)) u_fn (
    .mode(mode), .dir_q(dir_q), .is_addr(is_addr), .is_gpo(is_gpo)
  );

  mpio_pad_drv #(.W(W)) u_pad (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .hold_en(hold_en), .is_addr(is_addr), .is_gpo(is_gpo),
    .dat_q(dat_q), .od_q(od_q), .pu_q(pu_q), .addr_bus(addr_bus),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  mpio_rd_mux #(.W(W)) u_rd (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .hw_stby(hw_stby),
    .bus_rd(bus_rd), .sel(sel), .dat_q(dat_q), .pu_q(pu_q), .od_q(od_q),
    .is_gpo(is_gpo), .pad_in(pad_in), .bus_rdata(bus_rdata)
  );

  // R7: in expanded modes the fixed pins follow the address bus
  a_r7_fixed_addr: assert property (@(posedge clk) disable iff (por_rst)
    (addr_mode(mode) && !sw_stby && !hw_stby && !man_rst)
      |=> (pad_oe[AF-1:0] == '1 && pad_out[AF-1:0] == $past(addr_bus[AF-1:0])));

  // R12: modes with no function for the port leave every pin undriven
  a_r12_idle_modes: assert property (@(posedge clk) disable iff (por_rst)
    (mode == 3'd0 || mode == 3'd6) |=> (pad_oe == '0));

endmodule

// File: tb/mpio_port_tb_top.sv
module mpio_port_tb_top;

  logic        clk = 1'b0;
  logic        por_rst = 1'b1;
  logic        man_rst = 1'b0;
  logic        hw_stby = 1'b0;
  logic        sw_stby = 1'b0;
  logic        hold_en = 1'b0;
  logic [2:0]  mode = 3'd1;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  addr_bus = 8'h00;
  logic [7:0]  pad_in = 8'h00;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;
  logic [7:0]  pad_pu;

  always #4 clk = ~clk;

  mpio_port dut_i (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .hold_en(hold_en), .mode(mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .addr_bus(addr_bus), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu)
  );

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R13";
  bit    finished = 1'b0;

  // Behavioural reference model, advanced on every rising edge
  logic [7:0] m_dir = 8'h00, m_dat = 8'h00, m_pu = 8'h00, m_od = 8'h00;
  logic [7:0] e_out = 8'h00, e_oe = 8'h00, e_pu = 8'h00, e_rd = 8'h00;
  bit         mvalid = 1'b0;

  always @(posedge clk) begin : model
    logic [7:0] n_out, n_oe, n_pu, n_rd, pinv;
    bit am, gm;
    am = (mode == 3'd4) || (mode == 3'd5);
    gm = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd3) || (mode == 3'd7);
    for (int i = 0; i < 8; i++) begin
      bit ad, go;
      ad = am && (i < 5 || m_dir[i]);
      go = gm && m_dir[i];
      pinv[i] = go ? m_dat[i] : pad_in[i];
      n_pu[i] = 1'b0;
      if (ad) begin
        if (sw_stby) begin
          n_oe[i]  = hold_en;
          n_out[i] = hold_en ? e_out[i] : 1'b0;
        end else begin
          n_oe[i]  = 1'b1;
          n_out[i] = addr_bus[i];
        end
      end else if (go) begin
        if (m_od[i]) begin
          n_out[i] = 1'b0;
          n_oe[i]  = !m_dat[i];
        end else begin
          n_out[i] = m_dat[i];
          n_oe[i]  = 1'b1;
        end
      end else begin
        n_out[i] = 1'b0;
        n_oe[i]  = 1'b0;
        n_pu[i]  = m_pu[i];
      end
    end
    n_rd = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        16'hFEB9: n_rd = 8'hFF;
        16'hFF69: n_rd = m_dat;
        16'hFF59: n_rd = pinv;
        16'hFF70: n_rd = m_pu;
        16'hFF77: n_rd = m_od;
        default:  n_rd = 8'h00;
      endcase
    end
    if (por_rst || hw_stby) begin
      m_dir = 0; m_dat = 0; m_pu = 0; m_od = 0;
      e_out = 0; e_oe = 0; e_pu = 0; e_rd = 0;
      mvalid = 1'b1;
    end else if (man_rst) begin
      m_dat = 0; m_pu = 0; m_od = 0;
      e_out = 0; e_oe = 0; e_pu = 0; e_rd = 0;
    end else begin
      e_out = n_out; e_oe = n_oe; e_pu = n_pu; e_rd = n_rd;
      if (bus_wr) begin
        case (bus_addr)
          16'hFEB9: m_dir = bus_wdata;
          16'hFF69: m_dat = bus_wdata;
          16'hFF70: m_pu  = bus_wdata;
          16'hFF77: m_od  = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (mvalid && !finished) begin
      chk(cur_req, "cycle pad_out", pad_out, e_out);
      chk(cur_req, "cycle pad_oe", pad_oe, e_oe);
      chk(cur_req, "cycle pad_pu", pad_pu, e_pu);
      chk(cur_req, "cycle bus_rdata", bus_rdata, e_rd);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    idle(2);
    por_rst = 1'b0;
    cur_req = "R4";
    chk("R4", "reset pad_oe", pad_oe, 8'h00);
    chk("R4", "reset pad_out", pad_out, 8'h00);
    chk("R4", "reset rdata", bus_rdata, 8'h00);

    // General-purpose mode
    cur_req = "R6";
    wr(16'hFEB9, 8'hF0);
    wr(16'hFF69, 8'hA5);
    idle(1);
    chk("R6", "gp oe", pad_oe, 8'hF0);
    chk("R6", "gp out", pad_out, 8'hA0);
    pad_in = 8'h3C;
    cur_req = "R3";
    rd(16'hFF59, v); chk("R3", "pin read gp", v, 8'hAC);
    cur_req = "R2";
    rd(16'hFEB9, v); chk("R2", "dir read", v, 8'hFF);
    cur_req = "R1";
    rd(16'hFF69, v); chk("R1", "data read", v, 8'hA5);

    // Open drain
    cur_req = "R10";
    wr(16'hFF77, 8'h30);
    idle(1);
    chk("R10", "od oe", pad_oe, 8'hD0);
    chk("R10", "od out", pad_out, 8'h80);
    rd(16'hFF77, v); chk("R1", "od read", v, 8'h30);

    // Pull-ups
    cur_req = "R11";
    wr(16'hFF70, 8'hFF);
    idle(1);
    chk("R11", "pu gp", pad_pu, 8'h0F);
    wr(16'hFF77, 8'h00);

    // Expanded mode 4
    cur_req = "R8";
    @(negedge clk); mode = 3'd4; addr_bus = 8'h5A;
    wr(16'hFEB9, 8'hA0);
    idle(1);
    chk("R7", "mode4 oe", pad_oe, 8'hBF);
    chk("R8", "mode4 out", pad_out, 8'h1A);
    chk("R11", "mode4 pu", pad_pu, 8'h40);
    rd(16'hFF59, v); chk("R3", "pin read mode4", v, 8'h3C);

    // Software standby
    cur_req = "R9";
    @(negedge clk); hold_en = 1'b1; sw_stby = 1'b1;
    idle(1);
    @(negedge clk); addr_bus = 8'hFF;
    idle(2);
    chk("R9", "hold out", pad_out, 8'h1A);
    chk("R9", "hold oe", pad_oe, 8'hBF);
    @(negedge clk); hold_en = 1'b0;
    idle(1);
    chk("R9", "float oe", pad_oe, 8'h00);
    chk("R9", "float out", pad_out, 8'h00);
    @(negedge clk); sw_stby = 1'b0; addr_bus = 8'h5A;
    idle(1);

    // Manual reset
    cur_req = "R5";
    @(negedge clk); man_rst = 1'b1;
    @(negedge clk); man_rst = 1'b0;
    chk("R5", "man pads off", pad_oe, 8'h00);
    idle(1);
    chk("R5", "man dir kept", pad_oe, 8'hBF);
    @(negedge clk); mode = 3'd1;
    idle(1);
    chk("R5", "man dir gp oe", pad_oe, 8'hA0);
    chk("R5", "man data clear", pad_out, 8'h00);
    rd(16'hFF70, v); chk("R5", "man pu clear", v, 8'h00);

    // Hardware standby
    cur_req = "R4";
    wr(16'hFF70, 8'hFF);
    wr(16'hFF69, 8'hFF);
    @(negedge clk); hw_stby = 1'b1;
    idle(1);
    chk("R4", "hw oe", pad_oe, 8'h00);
    chk("R4", "hw pu", pad_pu, 8'h00);
    @(negedge clk); hw_stby = 1'b0;
    idle(1);
    chk("R4", "hw dir cleared", pad_oe, 8'h00);

    // Power-on reset clears direction
    wr(16'hFEB9, 8'h0F);
    wr(16'hFF69, 8'h0F);
    idle(1);
    chk("R6", "gp low nibble", pad_out, 8'h0F);
    @(negedge clk); por_rst = 1'b1;
    @(negedge clk); por_rst = 1'b0;
    idle(1);
    chk("R4", "por dir cleared", pad_oe, 8'h00);

    // Modes with no port function
    cur_req = "R12";
    wr(16'hFF70, 8'hFF);
    wr(16'hFEB9, 8'hFF);
    @(negedge clk); mode = 3'd6;
    idle(1);
    chk("R12", "mode6 oe", pad_oe, 8'h00);
    chk("R12", "mode6 pu", pad_pu, 8'hFF);
    @(negedge clk); mode = 3'd0;
    idle(1);
    chk("R12", "mode0 oe", pad_oe, 8'h00);

    // Unmapped and read-only addresses
    cur_req = "R1";
    rd(16'h1234, v); chk("R1", "unmapped read", v, 8'h00);
    wr(16'hFF71, 8'h55);
    wr(16'hFF59, 8'h00);
    rd(16'hFF70, v); chk("R1", "pu untouched", v, 8'hFF);

    // Expanded mode 5 with all direction bits clear
    cur_req = "R7";
    @(negedge clk); mode = 3'd5; addr_bus = 8'hC3;
    wr(16'hFEB9, 8'h00);
    idle(1);
    chk("R7", "mode5 oe", pad_oe, 8'h1F);
    chk("R8", "mode5 out", pad_out, 8'h03);
    chk("R11", "mode5 pu", pad_pu, 8'hE0);

    // Latency of pad update after a write
    cur_req = "R13";
    @(negedge clk); mode = 3'd1;
    wr(16'hFF69, 8'h3C);
    wr(16'hFEB9, 8'hFF);
    chk("R13", "oe before update", pad_oe, 8'h00);
    idle(1);
    chk("R13", "oe after update", pad_oe, 8'hFF);
    chk("R6", "out after update", pad_out, 8'h3C);

    idle(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule